// File: doc/BRIEF.md
# Key Event Queue

This block sits between a key-matrix scanner and a register interface. The scanner hands it debounced key events for a 64-key matrix: a press or release of one key, or an autorepeat marker. The block keeps them in arrival order in a queue of 16 entries. A host polls the queue through a single byte. That byte carries the oldest event, its type and whether more data waits, so one register read is enough to drain the queue step by step.

The read byte always shows what the next read would return. A pop strobe from the register interface consumes it. Some values are reserved as status codes: one for an empty queue, one for lost events and two for autorepeat. Keys 62 and 63 would collide with these codes, so they get their own encoding, and the host learns whether data remains by reading once more.

A sleep input marks low-power periods. The stored events survive them and stay readable, and a clear request during sleep is refused. The entry count feeds interrupt threshold logic elsewhere.

Top module: `key_event_queue`

## Requirements
- R1: The queue stores up to DEPTH (16) events, and `ev_count` reports the number of stored events, 0 to 16, one cycle after each push or pop edge.
- R2: For a stored key event with key number 0 to 61, `rd_byte[5:0]` is the key number, `rd_byte[6]` is 1 for a release and 0 for a press, and `rd_byte[7]` is 1 when more than one entry is stored and 0 when this is the last entry.
- R3: With no stored entries and no pending loss, `rd_byte` is 0x3F, and a pop in that state changes nothing.
- R4: An autorepeat entry reads as 0x3E when it is the only entry and as 0x7E when more entries follow.
- R5: A key event for key 62 or 63 reads as 0x80 OR key for a press and 0xC0 OR key for a release, whatever the number of entries behind it.
- R6: A push while 16 entries are stored and no entry is popped is discarded, the count stays 16 and `ovf_flag` goes to 1.
- R7: While `ovf_flag` is 1, `rd_byte` is 0x7F. A pop then clears the flag without removing an entry, and the stored entries follow unchanged.
- R8: A pop and a push in the same cycle both take effect. When the queue is full, the popped slot receives the pushed event. When the queue is empty, the push is stored and the pop has no effect.
- R9: If `ev_push` and `ev_repeat` are high in the same cycle, only the key event is stored.
- R10: A clear while `sleep` is 0 empties the queue and drops the loss flag in the next cycle, and it takes priority over a push or pop in the same cycle.
- R11: While `sleep` is 1, `q_clear` is ignored: stored entries, count and read byte stay as they were, and reads and pushes still work.
- R12: Entries are returned in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_push | input | 1 | Store a key event this cycle |
| ev_key | input | 6 | Key number of the pushed event |
| ev_release | input | 1 | 1 for a release, 0 for a press |
| ev_repeat | input | 1 | Store an autorepeat marker this cycle |
| rd_pop | input | 1 | Consume the value shown on rd_byte |
| q_clear | input | 1 | Empty the queue and drop the loss flag |
| sleep | input | 1 | Low-power state; blocks q_clear |
| rd_byte | output | 8 | Formatted next read value |
| ev_count | output | 5 | Number of stored events |
| ovf_flag | output | 1 | An event was lost and is not yet reported |

## Verification
The interesting collision is a pop and a push landing in the same cycle. It matters most when the queue is full, when it is empty, or when the pop is taken by a pending loss report. The bench forces each of these edges directly. It then keeps random traffic near the full mark so that they recur many times. Every cycle, the read byte, count and loss flag are compared against a reference queue in the bench. That queue applies the pop before judging whether the push fits.

// File: rtl/kevq_pkg.sv
package kevq_pkg;

    localparam int KEY_W = 6;

    localparam logic [7:0] CODE_EMPTY    = 8'h3F;
    localparam logic [7:0] CODE_LOST     = 8'h7F;
    localparam logic [7:0] CODE_REP_LAST = 8'h3E;
    localparam logic [7:0] CODE_REP_MORE = 8'h7E;

    localparam logic [KEY_W-1:0] FIRST_ALIAS_KEY = 6'd62;

    typedef struct packed {
        logic             rep;
        logic             rel;
        logic [KEY_W-1:0] key;
    } kev_t;

    typedef enum logic [1:0] {
        VIEW_EMPTY = 2'd0,
        VIEW_LOST  = 2'd1,
        VIEW_ENTRY = 2'd2
    } view_e;

    function automatic logic key_aliases(input logic [KEY_W-1:0] key);
        return key >= FIRST_ALIAS_KEY;
    endfunction

    function automatic logic [7:0] encode_entry(input kev_t e, input logic more);
        logic [7:0] b;
        if (e.rep) begin
            b = more ? CODE_REP_MORE : CODE_REP_LAST;
        end else if (key_aliases(e.key)) begin
            b = {1'b1, e.rel, e.key};
        end else begin
            b = {more, e.rel, e.key};
        end
        return b;
    endfunction

endpackage

// File: rtl/kevq_ctrl.sv
module kevq_ctrl #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             clear_req,
    input  logic             sleep,
    input  logic [CNT_W-1:0] count,
    output logic             wr_en,
    output logic             rd_en,
    output logic             flush,
    output logic             lost
);

    logic lost_q;
    logic lost_d;
    logic pop_on_lost;
    logic room;
    logic drop;

    always_comb begin
        flush       = clear_req & ~sleep;
        pop_on_lost = pop_req & lost_q & ~flush;
        rd_en       = pop_req & ~lost_q & (count != '0) & ~flush;
        room        = (count < CNT_W'(DEPTH)) | rd_en;
        wr_en       = push_req & room & ~flush;
        drop        = push_req & ~room & ~flush;
    end

    always_comb begin
        if (flush) begin
            lost_d = 1'b0;
        end else if (drop) begin
            lost_d = 1'b1;
        end else if (pop_on_lost) begin
            lost_d = 1'b0;
        end else begin
            lost_d = lost_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lost_q <= 1'b0;
        end else begin
            lost_q <= lost_d;
        end
    end

    assign lost = lost_q;

endmodule

// File: rtl/kevq_store.sv
module kevq_store
    import kevq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  kev_t             wr_data,
    input  logic             rd_en,
    input  logic             flush,
    output kev_t             head,
    output logic [CNT_W-1:0] count
);

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    kev_t             slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(i)) begin
                slots[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= advance(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= advance(rd_ptr);
            end
            case ({wr_en, rd_en})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign count = count_q;

endmodule

// File: rtl/kevq_fmt.sv
module kevq_fmt
    import kevq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  kev_t             head,
    input  logic [CNT_W-1:0] count,
    input  logic             lost,
    output logic [7:0]       rd_byte
);

    view_e view;
    logic  more;

    always_comb begin
        if (lost) begin
            view = VIEW_LOST;
        end else if (count == '0) begin
            view = VIEW_EMPTY;
        end else begin
            view = VIEW_ENTRY;
        end
        more = count > CNT_W'(1);
    end

    always_comb begin
        case (view)
            VIEW_LOST:  rd_byte = CODE_LOST;
            VIEW_ENTRY: rd_byte = encode_entry(head, more);
            default:    rd_byte = CODE_EMPTY;
        endcase
    end

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kevq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_push,
    input  logic [KEY_W-1:0] ev_key,
    input  logic             ev_release,
    input  logic             ev_repeat,
    input  logic             rd_pop,
    input  logic             q_clear,
    input  logic             sleep,
    output logic [7:0]       rd_byte,
    output logic [CNT_W-1:0] ev_count,
    output logic             ovf_flag
);

    kev_t             new_entry;
    kev_t             head;
    logic [CNT_W-1:0] count;
    logic             wr_en;
    logic             rd_en;
    logic             flush;
    logic             lost;

    // A key event wins over an autorepeat marker raised in the same cycle.
    always_comb begin
        if (ev_push) begin
            new_entry = '{rep: 1'b0, rel: ev_release, key: ev_key};
        end else begin
            new_entry = '{rep: 1'b1, rel: 1'b0, key: '0};
        end
    end

    kevq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_req  (ev_push | ev_repeat),
        .pop_req   (rd_pop),
        .clear_req (q_clear),
        .sleep     (sleep),
        .count     (count),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .flush     (flush),
        .lost      (lost)
    );

    kevq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (new_entry),
        .rd_en   (rd_en),
        .flush   (flush),
        .head    (head),
        .count   (count)
    );

    kevq_fmt #(.DEPTH(DEPTH)) u_fmt (
        .head    (head),
        .count   (count),
        .lost    (lost),
        .rd_byte (rd_byte)
    );

    assign ev_count = count;
    assign ovf_flag = lost;

endmodule

// File: rtl/kevq_checker.sv
module kevq_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ev_push,
    input logic             ev_repeat,
    input logic             rd_pop,
    input logic             q_clear,
    input logic             sleep,
    input logic [7:0]       rd_byte,
    input logic [CNT_W-1:0] ev_count,
    input logic             ovf_flag
);

    logic any_push;
    logic do_clear;
    assign any_push = ev_push | ev_repeat;
    assign do_clear = q_clear & ~sleep;

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        ev_count <= CNT_W'(DEPTH));

    a_r2_more_bit: assert property (@(posedge clk) disable iff (rst)
        (!ovf_flag && ev_count > CNT_W'(1) && rd_byte[5:1] != 5'h1F) |-> rd_byte[7]);

    a_r3_empty_code: assert property (@(posedge clk) disable iff (rst)
        (ev_count == '0 && !ovf_flag) |-> rd_byte == 8'h3F);

    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (ev_count == CNT_W'(DEPTH) && any_push && !rd_pop && !do_clear)
        |=> (ovf_flag && ev_count == CNT_W'(DEPTH)));

    a_r7_lost_code: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> rd_byte == 8'h7F);

    a_r7_lost_pop: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && rd_pop && !any_push && !do_clear)
        |=> (!ovf_flag && ev_count == $past(ev_count)));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        do_clear |=> (ev_count == '0 && !ovf_flag));

    a_r11_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        (sleep && !any_push && !rd_pop)
        |=> (ev_count == $past(ev_count) && rd_byte == $past(rd_byte)));

endmodule

bind key_event_queue kevq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_push   (ev_push),
    .ev_repeat (ev_repeat),
    .rd_pop    (rd_pop),
    .q_clear   (q_clear),
    .sleep     (sleep),
    .rd_byte   (rd_byte),
    .ev_count  (ev_count),
    .ovf_flag  (ovf_flag)
);

// File: tb/sim_key_event_queue.sv
`timescale 1ns/1ps
module sim_key_event_queue;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_push = 1'b0;
    logic [5:0] ev_key = '0;
    logic       ev_release = 1'b0;
    logic       ev_repeat = 1'b0;
    logic       rd_pop = 1'b0;
    logic       q_clear = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] rd_byte;
    logic [4:0] ev_count;
    logic       ovf_flag;

    always #5 clk = ~clk;

    key_event_queue #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .ev_push(ev_push), .ev_key(ev_key),
        .ev_release(ev_release), .ev_repeat(ev_repeat), .rd_pop(rd_pop),
        .q_clear(q_clear), .sleep(sleep), .rd_byte(rd_byte),
        .ev_count(ev_count), .ovf_flag(ovf_flag)
    );

    // Reference queue entries: {rep, rel, key}
    logic [7:0] mq[$];
    logic       m_lost = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    string      pend_tag = "";

    function automatic logic [7:0] exp_byte();
        logic [7:0] e;
        logic more;
        if (m_lost) return 8'h7F;
        if (mq.size() == 0) return 8'h3F;
        e = mq[0];
        more = mq.size() > 1;
        if (e[7]) return more ? 8'h7E : 8'h3E;
        if (e[5:0] >= 6'd62) return e[6] ? (8'hC0 | {2'b00, e[5:0]}) : (8'h80 | {2'b00, e[5:0]});
        return {more, e[6], e[5:0]};
    endfunction

    function automatic string byte_tag();
        if (m_lost) return "R7";
        if (mq.size() == 0) return "R3";
        if (mq[0][7]) return "R4";
        if (mq[0][5:0] >= 6'd62) return "R5";
        return "R2";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string tb, tc, tl;
        tb = (pend_tag != "") ? pend_tag : byte_tag();
        tc = (pend_tag != "") ? pend_tag : "R1";
        tl = (pend_tag != "") ? pend_tag : "R6";
        chk({tb, " read byte"}, int'(rd_byte), int'(exp_byte()));
        chk({tc, " count"}, int'(ev_count), mq.size());
        chk({tl, " loss flag"}, int'(ovf_flag), int'(m_lost));
    endtask

    task automatic model_update(input logic ps, input logic [5:0] k, input logic rl,
                                input logic rp, input logic pp, input logic cl,
                                input logic sl);
        logic took_lost;
        logic dropped;
        took_lost = 1'b0;
        dropped = 1'b0;
        if (cl && !sl) begin
            mq.delete();
            m_lost = 1'b0;
        end else begin
            if (pp) begin
                if (m_lost) took_lost = 1'b1;
                else if (mq.size() > 0) void'(mq.pop_front());
            end
            if (ps || rp) begin
                if (mq.size() < DEPTH) mq.push_back(ps ? {1'b0, rl, k} : 8'h80);
                else dropped = 1'b1;
            end
            if (dropped) m_lost = 1'b1;
            else if (took_lost) m_lost = 1'b0;
        end
    endtask

    task automatic step(input logic ps, input logic [5:0] k, input logic rl,
                        input logic rp, input logic pp, input logic cl,
                        input logic sl, input string tag);
        @(negedge clk);
        check_all();
        model_update(ps, k, rl, rp, pp, cl, sl);
        ev_push = ps; ev_key = k; ev_release = rl; ev_repeat = rp;
        rd_pop = pp; q_clear = cl; sleep = sl;
        pend_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pend_tag = "R3";
        // Reset state, then a pop on empty (R3)
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        idle("R3");
        // Order and encodings (R12, R2, R4, R5)
        step(1'b1, 6'd5,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b1, 6'd9,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        step(1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b1, 6'd62, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        step(1'b1, 6'd63, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        for (int i = 0; i < 6; i++) step(1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R12");
        // Key event and repeat in one cycle (R9)
        step(1'b1, 6'd17, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        idle("R9");
        step(1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        idle("R4");
        // Fill to the top, then overflow (R1, R6, R7)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 6'(i + 20), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        step(1'b1, 6'd40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        idle("R6");
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        idle("R7");
        // Pop and push together at full (R8)
        step(1'b1, 6'd61, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        idle("R8");
        // Clear during sleep is refused (R11); clear awake empties (R10)
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
        step(1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
        step(1'b1, 6'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11");
        idle("R10");
        // Pop and push together on empty (R8)
        step(1'b1, 6'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R10");
        idle("R8");
        // Random traffic biased towards the full boundary
        for (int c = 0; c < 6000; c++) begin
            logic ps, rp, pp, cl, sl, rl;
            logic [5:0] k;
            ps = ($urandom % 100) < 55;
            rp = ($urandom % 100) < 12;
            pp = ($urandom % 100) < ((c % 800) < 400 ? 30 : 60);
            cl = ($urandom % 1000) < 8;
            sl = ($urandom % 100) < 15;
            rl = $urandom % 2;
            k  = (($urandom % 4) == 0) ? 6'(62 + ($urandom % 2)) : 6'($urandom % 64);
            step(ps, k, rl, rp, pp, cl, sl, "");
        end
        idle("");
        @(negedge clk);
        check_all();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule